// File: doc/BRIEF.md
# Dual-Mode DMA Byte Counter

This block keeps the 32-bit byte count of a DMA channel. Each cycle the channel's datapath reports how many bytes it moved, from one to four. A mode input picks one of two uses for the same register. In tally mode the register sums the bytes moved and raises a sticky status bit each time it wraps past its top value. In countdown mode software first loads the number of bytes to move. The register then counts down to zero, and at zero the transfer ends by itself with a one-cycle done pulse.

Software reaches the count through four byte-wide registers on a plain read/write strobe bus. It may load these registers only while no transfer runs. Reads must begin at the most significant byte. That read freezes a copy of the whole count, and the three lower bytes then return the frozen copy. A multi-byte read therefore stays consistent even while the count keeps moving.

Top module: `dma_byte_tally`

## Requirements
- R1: After reset the count is 0, and `active`, `done` and `wrap_flag` are all 0.
- R2: Register address 0 holds count bits 31:24, address 1 bits 23:16, address 2 bits 15:8 and address 3 bits 7:0. A write while idle replaces only the addressed byte, and it takes effect at the clock edge of the write.
- R3: With `cnt_mode`=0 and `active`=1, every cycle with `xfer_vld`=1 adds `xfer_bytes` (1 to 4) to the count.
- R4: In tally mode, a sum beyond 0xFFFFFFFF keeps only its low 32 bits and sets `wrap_flag`. The flag holds until a cycle with `wrap_clr`=1 clears it. If a clear and a wrap fall in the same cycle, the flag stays set.
- R5: With `cnt_mode`=1 and `active`=1, every cycle with `xfer_vld`=1 subtracts `xfer_bytes`. The count stops at 0 and never goes below it.
- R6: In countdown mode, `active` falls in the same cycle that the count becomes 0, and `done` is high for exactly that one cycle.
- R7: A register write while `active`=1 leaves the count unchanged.
- R8: A read strobe at address 0 returns the live count bits 31:24 and freezes the whole count at that edge. Reads at addresses 1 to 3 return bytes of the frozen copy.
- R9: When `go` arrives while idle in countdown mode with a count of 0, `done` pulses in the next cycle, `active` stays 0 and no bytes are counted.
- R10: `go` while idle raises `active`. In tally mode `active` stays high until `stop`, and `stop` brings no `done` pulse. `xfer_vld` while idle leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| cnt_mode | input | 1 | 0 = tally up, 1 = count down to zero |
| go | input | 1 | Start strobe, ignored while active |
| stop | input | 1 | Abort strobe, clears active |
| xfer_vld | input | 1 | Datapath moved bytes this cycle |
| xfer_bytes | input | 3 | Bytes moved this cycle, 1 to 4 |
| wrap_clr | input | 1 | Write-one clear of the wrap flag |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Byte register select, 0 = most significant |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the address |
| active | output | 1 | Transfer running |
| done | output | 1 | One-cycle pulse at countdown end |
| wrap_flag | output | 1 | Sticky tally wrap status |

## Verification
If the held count is wrong, it shows only through a register read. It also drives the countdown end, so a bad value makes `done` and the fall of `active` arrive early or late, by one cycle or more. A bad frozen copy appears on the first read of address 1 to 3 that follows the freezing read. A bad wrap or active state shows at the port on the next clock edge. The bench keeps its own copy of the count and checks every register read against it, and it compares `active`, `done` and `wrap_flag` after every edge, so a fault is reported within the cycle in which it becomes visible.

// File: rtl/tally_pkg.sv
package tally_pkg;
  localparam int TALLY_W = 32;
  localparam int STEP_W  = 3;

  typedef logic [TALLY_W-1:0] tally_t;
  typedef logic [STEP_W-1:0]  step_t;

  // Widen a step amount to the counter width.
  function automatic tally_t step_ext(step_t s);
    return {{(TALLY_W-STEP_W){1'b0}}, s};
  endfunction

  // Up-count with the carry kept in the top bit.
  function automatic logic [TALLY_W:0] tally_up(tally_t c, step_t s);
    return {1'b0, c} + {1'b0, step_ext(s)};
  endfunction

  // Down-count that stops at zero.
  function automatic tally_t tally_down(tally_t c, step_t s);
    tally_t e;
    e = step_ext(s);
    return (c > e) ? (c - e) : '0;
  endfunction
endpackage

// File: rtl/tally_core.sv
module tally_core
  import tally_pkg::*;
#(
  parameter int NB = TALLY_W / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_mode,
  input  logic          go,
  input  logic          stop,
  input  logic          xfer_vld,
  input  step_t         xfer_bytes,
  input  logic          wrap_clr,
  input  logic [NB-1:0] byte_we,
  input  logic [7:0]    wdata,
  output tally_t        count_o,
  output logic          active_o,
  output logic          done_o,
  output logic          wrap_o
);
  tally_t cnt_q, cnt_step, cnt_d;
  logic   active_q, done_q, wrap_q;
  logic [TALLY_W:0] up_sum;

  // Named internal events
  logic counting, wrap_evt, zero_hit, go_start, go_empty;

  assign up_sum   = tally_up(cnt_q, xfer_bytes);
  assign counting = active_q & xfer_vld;
  assign wrap_evt = counting & ~cnt_mode & up_sum[TALLY_W];

  always_comb begin
    cnt_step = cnt_q;
    if (counting)
      cnt_step = cnt_mode ? tally_down(cnt_q, xfer_bytes) : up_sum[TALLY_W-1:0];
  end

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_byte
      assign cnt_d[8*b +: 8] = byte_we[b] ? wdata : cnt_step[8*b +: 8];
    end
  endgenerate

  assign zero_hit = active_q & cnt_mode & (cnt_step == '0);
  assign go_start = go & ~active_q;
  assign go_empty = go_start & cnt_mode & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      wrap_q   <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      active_q <= active_q ? ~(zero_hit | stop) : (go_start & ~go_empty);
      done_q   <= zero_hit | go_empty;
      wrap_q   <= wrap_evt | (wrap_q & ~wrap_clr);
    end
  end

  assign count_o  = cnt_q;
  assign active_o = active_q;
  assign done_o   = done_q;
  assign wrap_o   = wrap_q;

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && cnt_mode && xfer_vld && (cnt_q <= step_ext(xfer_bytes)) |=> (cnt_q == '0)); // R5
  AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_q && !wrap_clr |=> wrap_q); // R4
  AST_WRAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (cnt_q < step_ext(3'd4))); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !active_q); // R6
  AST_ACTIVE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && !xfer_vld |=> $stable(cnt_q)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q && (byte_we == '0) |=> $stable(cnt_q)); // R10
endmodule

// File: rtl/tally_regif.sv
module tally_regif
  import tally_pkg::*;
#(
  parameter int NB     = TALLY_W / 8,
  parameter int ADDR_W = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              active_i,
  input  tally_t            count_i,
  output logic [NB-1:0]     byte_we,
  output logic [7:0]        reg_rdata
);
  tally_t snap_q;
  logic   head_rd;

  assign head_rd = reg_rd & (reg_addr == '0);

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_we
      localparam logic [ADDR_W-1:0] BYTE_ADDR = ADDR_W'(NB - 1 - b);
      assign byte_we[b] = reg_wr & ~active_i & (reg_addr == BYTE_ADDR);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) snap_q <= '0;
    else if (head_rd) snap_q <= count_i;
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NB; i++) begin
      if (reg_addr == ADDR_W'(NB - 1 - i))
        reg_rdata = (reg_addr == '0) ? count_i[8*i +: 8] : snap_q[8*i +: 8];
    end
  end

  AST_SNAP_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    head_rd |=> (snap_q == $past(count_i))); // R8
  AST_ONE_BYTE_WR: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && !active_i |-> ($countones(byte_we) == 1)); // R2
endmodule

// File: rtl/dma_byte_tally.sv
module dma_byte_tally
  import tally_pkg::*;
#(
  parameter int CNT_W  = TALLY_W,
  parameter int XB_W   = STEP_W,
  localparam int NB     = CNT_W / 8,
  localparam int ADDR_W = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_mode,
  input  logic              go,
  input  logic              stop,
  input  logic              xfer_vld,
  input  logic [XB_W-1:0]   xfer_bytes,
  input  logic              wrap_clr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              active,
  output logic              done,
  output logic              wrap_flag
);
  tally_t        count;
  logic [NB-1:0] byte_we;

  tally_regif #(.NB(NB), .ADDR_W(ADDR_W)) u_regif (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .active_i  (active),
    .count_i   (count),
    .byte_we   (byte_we),
    .reg_rdata (reg_rdata)
  );

  tally_core #(.NB(NB)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_mode   (cnt_mode),
    .go         (go),
    .stop       (stop),
    .xfer_vld   (xfer_vld),
    .xfer_bytes (xfer_bytes),
    .wrap_clr   (wrap_clr),
    .byte_we    (byte_we),
    .wdata      (reg_wdata),
    .count_o    (count),
    .active_o   (active),
    .done_o     (done),
    .wrap_o     (wrap_flag)
  );

  AST_GO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(go)); // R10
endmodule

// File: tb/tb_dma_byte_tally.sv
module tb_dma_byte_tally;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_mode = 1'b0, s_go = 1'b0, s_stop = 1'b0, s_xv = 1'b0, s_clr = 1'b0;
  logic [2:0] s_xb = 3'd1;
  logic s_wr = 1'b0, s_rd = 1'b0;
  logic [1:0] s_addr = 2'd0;
  logic [7:0] s_wdata = 8'd0;
  logic [7:0] rdata;
  logic act_o, done_o, wrap_o;

  int errors = 0, checks = 0, cyc = 0;
  bit finished = 0;

  // Bench model of the counter
  logic [31:0] m_cnt = '0, m_snap = '0;
  logic m_act = 0, m_done = 0, m_wrap = 0;
  logic [7:0] last_rd;

  always #2 clk = ~clk;

  dma_byte_tally dut (
    .clk(clk), .rst_n(rst_n), .cnt_mode(s_mode), .go(s_go), .stop(s_stop),
    .xfer_vld(s_xv), .xfer_bytes(s_xb), .wrap_clr(s_clr),
    .reg_wr(s_wr), .reg_rd(s_rd), .reg_addr(s_addr), .reg_wdata(s_wdata),
    .reg_rdata(rdata), .active(act_o), .done(done_o), .wrap_flag(wrap_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    logic [31:0] src;
    src = (a == 2'd0) ? m_cnt : m_snap;
    return src[8*(3-a) +: 8];
  endfunction

  // Called at a falling edge with the stimulus already set.
  task automatic tick(input string rtag);
    longint unsigned sum;
    logic [31:0] nc;
    logic na, nd, nw;
    #1;
    last_rd = rdata;
    if (s_rd) chk(rtag, {24'd0, rdata}, {24'd0, exp_rd(s_addr)});
    nc = m_cnt; na = m_act; nd = 0; nw = m_wrap & ~s_clr;
    if (m_act) begin
      if (s_xv) begin
        if (!s_mode) begin
          sum = longint'(m_cnt) + longint'(s_xb);
          if (sum > 64'hFFFF_FFFF) nw = 1;
          nc = sum[31:0];
        end else begin
          nc = (m_cnt <= {29'd0, s_xb}) ? 32'd0 : m_cnt - {29'd0, s_xb};
        end
      end
      if (s_mode && nc == 0) begin nd = 1; na = 0; end
      if (s_stop) na = 0;
    end else begin
      if (s_wr) nc[8*(3-s_addr) +: 8] = s_wdata;
      if (s_go) begin
        if (s_mode && m_cnt == 0) nd = 1;
        else na = 1;
      end
    end
    if (s_rd && s_addr == 2'd0) m_snap = m_cnt;
    @(posedge clk);
    m_cnt = nc; m_act = na; m_done = nd; m_wrap = nw;
    #1;
    chk("R6 active", {31'd0, act_o}, {31'd0, m_act});
    chk("R6/R9 done", {31'd0, done_o}, {31'd0, m_done});
    chk("R4 wrap_flag", {31'd0, wrap_o}, {31'd0, m_wrap});
    @(negedge clk);
    s_go = 0; s_stop = 0; s_xv = 0; s_clr = 0; s_wr = 0; s_rd = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick("R8");
  endtask

  task automatic wr_byte(input logic [1:0] a, input logic [7:0] d);
    s_wr = 1; s_addr = a; s_wdata = d; tick("R2");
  endtask

  task automatic load(input logic [31:0] v);
    for (int i = 0; i < 4; i++) wr_byte(2'(i), v[8*(3-i) +: 8]);
  endtask

  // Read all four bytes in order, optionally with transfers, compare to exp.
  task automatic read_all(input string tag, input logic [31:0] exp, input bit move);
    logic [31:0] got;
    for (int i = 0; i < 4; i++) begin
      s_rd = 1; s_addr = 2'(i);
      if (move) begin s_xv = 1; s_xb = 3'd3; end
      tick(tag);
      got[8*(3-i) +: 8] = last_rd;
    end
    chk(tag, got, exp);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7041));
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk("R1 active", {31'd0, act_o}, 32'd0);
    chk("R1 done", {31'd0, done_o}, 32'd0);
    chk("R1 wrap", {31'd0, wrap_o}, 32'd0);
    read_all("R1 count", 32'd0, 0);

    // R2: byte map
    load(32'h1234_5678);
    read_all("R2 byte map", 32'h1234_5678, 0);
    wr_byte(2'd2, 8'hC3);
    read_all("R2 single byte", 32'h1234_C378, 0);

    // R3, R4: tally and wrap
    s_mode = 0;
    load(32'hFFFF_FFFE);
    s_go = 1; tick("R10");
    s_xv = 1; s_xb = 3'd3; tick("R4");
    chk("R4 wrap set", {31'd0, wrap_o}, 32'd1);
    s_xv = 1; s_xb = 3'd4; tick("R3");
    read_all("R3 sum", 32'd5, 0);
    // R7: write while active ignored
    wr_byte(2'd3, 8'hAA);
    read_all("R7 locked", 32'd5, 0);
    s_clr = 1; tick("R4");
    chk("R4 cleared", {31'd0, wrap_o}, 32'd0);
    // R10: stop without done, idle transfer ignored
    s_stop = 1; tick("R10");
    chk("R10 stop", {30'd0, act_o, done_o}, 32'd0);
    s_xv = 1; s_xb = 3'd2; tick("R10");
    read_all("R10 idle xfer", 32'd5, 0);
    // R4: clear and wrap in the same cycle
    load(32'hFFFF_FFFF);
    s_go = 1; tick("R10");
    s_xv = 1; s_xb = 3'd1; s_clr = 1; tick("R4");
    chk("R4 set wins", {31'd0, wrap_o}, 32'd1);
    // R8: frozen copy while counting
    read_all("R8 snapshot", 32'd0, 1);
    s_stop = 1; tick("R10");
    s_clr = 1; tick("R4");

    // R5, R6: countdown with clamp
    s_mode = 1;
    load(32'd6);
    s_go = 1; tick("R6");
    s_xv = 1; s_xb = 3'd4; tick("R5");
    chk("R5 still active", {31'd0, act_o}, 32'd1);
    s_xv = 1; s_xb = 3'd4; tick("R5");
    chk("R6 done pulse", {30'd0, act_o, done_o}, 32'd1);
    tick("R6");
    chk("R6 done one cycle", {31'd0, done_o}, 32'd0);
    read_all("R5 clamp", 32'd0, 0);
    // R9: go with zero count
    s_go = 1; s_xv = 1; s_xb = 3'd2; tick("R9");
    chk("R9 empty go", {30'd0, act_o, done_o}, 32'd1);
    read_all("R9 no bytes", 32'd0, 0);

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      if (!m_act && $urandom_range(0, 19) == 0) s_mode = ~s_mode;
      s_go   = ($urandom_range(0, 9) == 0);
      s_stop = ($urandom_range(0, 39) == 0);
      s_xv   = $urandom_range(0, 1);
      s_xb   = 3'($urandom_range(1, 4));
      s_clr  = ($urandom_range(0, 15) == 0);
      s_wr   = ($urandom_range(0, 7) == 0);
      s_rd   = ($urandom_range(0, 2) == 0);
      s_addr = 2'($urandom_range(0, 3));
      s_wdata = (s_addr == 2'd3 && $urandom_range(0, 1) == 1) ? 8'd0 : 8'($urandom);
      if (s_wr && s_mode && $urandom_range(0, 1) == 1) s_wdata = 8'hFF;
      if ($urandom_range(0, 3) == 0 && !s_mode && !m_act) s_wdata = 8'hFF;
      tick("R8 random read");
    end
    idle(2);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule